// File: doc/BRIEF.md
# Banked Address Register File with Shadow Halves

This block holds the pointer state of one address generator: eight index, eight modify, eight base and eight length registers, each with a primary and an alternate copy. Two select inputs choose which copy is visible. One covers slots 0 to 3 and the other covers slots 4 to 7, so a context switch can swap one half while the other half keeps passing pointers across contexts. Writing a base register also loads the matching index register, which is how a circular buffer is armed in a single step.

The address generator uses a direct write port and combinational taps. One tap returns the index, base and length of a chosen slot, and a second tap returns the modify value of any slot. The block also moves registers to and from a 40-bit data bus. Bus writes form a valid/ready stream. A bus write stalls (`bw_ready` low) in any cycle where the generator's own write port is active. Bus reads are a request stream with a one-entry response stream. A new request is accepted only when the response slot is empty or is draining in the same cycle. A response that is not taken keeps its value and stays valid. The register width is a parameter (24 or 32). With narrow registers the bus transfer extends each value according to its kind.

Top module: `addr_bank_regfile`

## Requirements
- R1: Reset clears every register in both copies to zero and leaves the response stream empty (`rsp_valid` low).
- R2: A write on the generator port (`wr_en`) stores `wr_data` into the visible copy of the register given by `wr_kind` and `wr_idx`. The `ag_*` taps show the visible copies combinationally from the next cycle on.
- R3: Writing a base register, from either port, stores the same value into the index register of the same slot and copy. Writing an index register leaves the base register unchanged.
- R4: `sel_lo` decides the copy for slots 0–3 and `sel_hi` decides the copy for slots 4–7 (0 = primary, 1 = alternate). A copy keeps its contents while it is not visible, and a select bit has no effect on the other half.
- R5: An accepted bus write takes register bits from bus bits REG_W+7:8 and ignores all other bus bits.
- R6: A bus read response carries the register on bits 39:8 with bits 7:0 zero. When REG_W < 32, modify registers are sign-extended to 32 bits and index, base and length registers are zero-filled.
- R7: `bw_ready` is low while `wr_en` is high. `rq_ready` equals `!rsp_valid || rsp_ready`. A response held with `rsp_ready` low stays valid with the same data.
- R8: The kind code on `wr_kind`, `bw_kind` and `rq_kind` is 0 = index, 1 = modify, 2 = base, 3 = length. Slot numbers are 0–7.
- R9: The response to an accepted request becomes valid one cycle later. It reflects the register contents and selects at acceptance and does not include any write made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_lo | input | 1 | Copy select for slots 0–3 |
| sel_hi | input | 1 | Copy select for slots 4–7 |
| wr_en | input | 1 | Generator write strobe |
| wr_kind | input | 2 | Generator write register kind |
| wr_idx | input | 3 | Generator write slot |
| wr_data | input | REG_W | Generator write value |
| ag_sel | input | 3 | Slot for the index/base/length tap |
| ag_index | output | REG_W | Visible index of `ag_sel` |
| ag_base | output | REG_W | Visible base of `ag_sel` |
| ag_length | output | REG_W | Visible length of `ag_sel` |
| ag_msel | input | 3 | Slot for the modify tap |
| ag_modify | output | REG_W | Visible modify of `ag_msel` |
| bw_valid | input | 1 | Bus write valid |
| bw_ready | output | 1 | Bus write ready |
| bw_kind | input | 2 | Bus write register kind |
| bw_idx | input | 3 | Bus write slot |
| bw_data | input | 40 | Bus write data |
| rq_valid | input | 1 | Bus read request valid |
| rq_ready | output | 1 | Bus read request ready |
| rq_kind | input | 2 | Bus read register kind |
| rq_idx | input | 3 | Bus read slot |
| rsp_valid | output | 1 | Bus read response valid |
| rsp_ready | input | 1 | Bus read response ready |
| rsp_data | output | 40 | Bus read response data |

## Verification
The assertions assume that the kind and slot fields are stable and meaningful whenever their strobe or valid is high. They also assume the selects change only between transfers, because the visible copy is decided in the same cycle as the write. The stimulus changes selects, kinds and slots only on the falling edge and only with the strobes idle or about to be raised. It never lets a bus write and a generator write land together except in the directed stall case, where the design itself holds the bus write off.

// File: rtl/adrf_pkg.sv
package adrf_pkg;
  typedef enum logic [1:0] {
    K_IDX = 2'd0,
    K_MOD = 2'd1,
    K_BAS = 2'd2,
    K_LEN = 2'd3
  } reg_kind_e;

  localparam int BUS_W    = 40;
  localparam int LANE_LSB = 8;
  localparam int WORD_W   = 32;
  localparam int NKIND    = 4;
  localparam int NSLOT    = 8;
  localparam int NCOPY    = 2;
endpackage

// File: rtl/adrf_store.sv
module adrf_store
  import adrf_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             we,
  input  reg_kind_e        wkind,
  input  logic [2:0]       widx,
  input  logic [REG_W-1:0] wdata,
  input  reg_kind_e        ra_kind,
  input  logic [2:0]       ra_idx,
  output logic [REG_W-1:0] ra_data,
  input  logic [2:0]       ag_sel,
  output logic [REG_W-1:0] ag_index,
  output logic [REG_W-1:0] ag_base,
  output logic [REG_W-1:0] ag_length,
  input  logic [2:0]       ag_msel,
  output logic [REG_W-1:0] ag_modify
);
  localparam int TOTAL  = NCOPY * NKIND * NSLOT;
  localparam int ADDR_W = $clog2(TOTAL);

  logic [TOTAL-1:0][REG_W-1:0] regs;

  // Flat position of a register: {copy, kind, slot}; the copy comes from
  // the select of the half that the slot belongs to.
  function automatic logic [ADDR_W-1:0] flat(input logic lo, input logic hi,
                                             input reg_kind_e k,
                                             input logic [2:0] s);
    logic cp;
    cp = s[2] ? hi : lo;
    return {cp, k, s};
  endfunction

  logic [ADDR_W-1:0] wslot, islot, bslot;
  assign wslot = flat(sel_lo, sel_hi, wkind, widx);
  assign islot = flat(sel_lo, sel_hi, K_IDX, widx);
  assign bslot = flat(sel_lo, sel_hi, K_BAS, widx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      regs[wslot] <= wdata;
      if (wkind == K_BAS) regs[islot] <= wdata;
    end
  end

  assign ra_data   = regs[flat(sel_lo, sel_hi, ra_kind, ra_idx)];
  assign ag_index  = regs[flat(sel_lo, sel_hi, K_IDX, ag_sel)];
  assign ag_base   = regs[flat(sel_lo, sel_hi, K_BAS, ag_sel)];
  assign ag_length = regs[flat(sel_lo, sel_hi, K_LEN, ag_sel)];
  assign ag_modify = regs[flat(sel_lo, sel_hi, K_MOD, ag_msel)];

  // R3: a base write arms the paired index with the same value
  p_base_loads_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wkind == K_BAS) |=> (regs[$past(islot)] == $past(wdata)));

  // R3: an index write keeps the paired base
  p_index_keeps_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wkind == K_IDX) |=> (regs[$past(bslot)] == $past(regs[bslot])));

  // R4: nothing moves without a write strobe
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/adrf_bus_align.sv
module adrf_bus_align
  import adrf_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  reg_kind_e        out_kind,
  input  logic [REG_W-1:0] out_val,
  output logic [BUS_W-1:0] out_bus,
  input  logic [BUS_W-1:0] in_bus,
  output logic [REG_W-1:0] in_val
);
  localparam int EXT_W = WORD_W - REG_W;

  logic [WORD_W-1:0] word;

  generate
    if (EXT_W > 0) begin : g_extend
      logic fill;
      assign fill = (out_kind == K_MOD) ? out_val[REG_W-1] : 1'b0;
      assign word = {{EXT_W{fill}}, out_val};
    end else begin : g_full
      assign word = out_val[WORD_W-1:0];
    end
  endgenerate

  assign out_bus = {word, {LANE_LSB{1'b0}}};
  assign in_val  = in_bus[LANE_LSB +: REG_W];
endmodule

// File: rtl/adrf_rsp_slot.sv
module adrf_rsp_slot
  import adrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [BUS_W-1:0] load_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [BUS_W-1:0] rsp_data
);
  assign load_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load_ready) begin
      rsp_valid <= load_valid;
      if (load_valid) rsp_data <= load_data;
    end
  end

  // R7: a stalled response neither drops nor changes
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R9: an accepted request shows up on the next cycle
  p_rsp_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_valid && load_ready) |=> rsp_valid);
endmodule

// File: rtl/addr_bank_regfile.sv
module addr_bank_regfile
  import adrf_pkg::*;
#(
  parameter int REG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_lo,
  input  logic             sel_hi,
  input  logic             wr_en,
  input  logic [1:0]       wr_kind,
  input  logic [2:0]       wr_idx,
  input  logic [REG_W-1:0] wr_data,
  input  logic [2:0]       ag_sel,
  output logic [REG_W-1:0] ag_index,
  output logic [REG_W-1:0] ag_base,
  output logic [REG_W-1:0] ag_length,
  input  logic [2:0]       ag_msel,
  output logic [REG_W-1:0] ag_modify,
  input  logic             bw_valid,
  output logic             bw_ready,
  input  logic [1:0]       bw_kind,
  input  logic [2:0]       bw_idx,
  input  logic [39:0]      bw_data,
  input  logic             rq_valid,
  output logic             rq_ready,
  input  logic [1:0]       rq_kind,
  input  logic [2:0]       rq_idx,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [39:0]      rsp_data
);
  logic             bw_fire;
  logic             st_we;
  reg_kind_e        st_kind;
  logic [2:0]       st_idx;
  logic [REG_W-1:0] st_data;
  logic [REG_W-1:0] bus_val;
  logic [REG_W-1:0] rd_val;
  logic [BUS_W-1:0] rd_bus;

  // The generator port owns the write path; the bus waits for a free cycle.
  assign bw_ready = !wr_en;
  assign bw_fire  = bw_valid && bw_ready;
  assign st_we    = wr_en || bw_fire;
  assign st_kind  = wr_en ? reg_kind_e'(wr_kind) : reg_kind_e'(bw_kind);
  assign st_idx   = wr_en ? wr_idx : bw_idx;
  assign st_data  = wr_en ? wr_data : bus_val;

  adrf_store #(.REG_W(REG_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_lo   (sel_lo),
    .sel_hi   (sel_hi),
    .we       (st_we),
    .wkind    (st_kind),
    .widx     (st_idx),
    .wdata    (st_data),
    .ra_kind  (reg_kind_e'(rq_kind)),
    .ra_idx   (rq_idx),
    .ra_data  (rd_val),
    .ag_sel   (ag_sel),
    .ag_index (ag_index),
    .ag_base  (ag_base),
    .ag_length(ag_length),
    .ag_msel  (ag_msel),
    .ag_modify(ag_modify)
  );

  adrf_bus_align #(.REG_W(REG_W)) u_align (
    .out_kind(reg_kind_e'(rq_kind)),
    .out_val (rd_val),
    .out_bus (rd_bus),
    .in_bus  (bw_data),
    .in_val  (bus_val)
  );

  adrf_rsp_slot u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_valid(rq_valid),
    .load_ready(rq_ready),
    .load_data (rd_bus),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );

  // R6: the low byte lane of every response is clear
  p_rsp_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_data[LANE_LSB-1:0] == '0));

  // R7: a bus write is never taken alongside a generator write
  p_bus_yields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bw_valid) |=> !$past(bw_fire));
endmodule

// File: tb/test_addr_bank_regfile.sv
module test_addr_bank_regfile;
  localparam int RW = 24;
  localparam int VW = 89;
  localparam int NV = 16;
  // op: 0 generator write, 1 bus write, 2 bus read and compare
  localparam logic [NV-1:0][VW-1:0] VEC = {
    {2'd2, 1'b1, 1'b1, 2'd1, 3'd1, 40'h0, 40'h0000000000},     // 15 R4 alt M1 empty
    {2'd2, 1'b0, 1'b0, 2'd1, 3'd5, 40'h0, 40'h0000000000},     // 14 R4 primary M5 empty
    {2'd2, 1'b0, 1'b1, 2'd1, 3'd5, 40'h0, 40'hFF80000A00},     // 13 R6 sign extension
    {2'd1, 1'b0, 1'b1, 2'd1, 3'd5, 40'h1280000A34, 40'h0},     // 12 R5 bus write M5 alt
    {2'd2, 1'b0, 1'b1, 2'd1, 3'd1, 40'h0, 40'hFF80001000},     // 11 R4 sel_hi no effect low
    {2'd2, 1'b0, 1'b0, 2'd3, 3'd0, 40'h0, 40'h0000000000},     // 10 R4 primary L0 kept
    {2'd2, 1'b1, 1'b0, 2'd3, 3'd0, 40'h0, 40'h0000010000},     // 9  R4 alt L0
    {2'd0, 1'b1, 1'b0, 2'd3, 3'd0, 40'h0000000100, 40'h0},     // 8  R2 write alt L0
    {2'd2, 1'b0, 1'b0, 2'd2, 3'd2, 40'h0, 40'h0012345600},     // 7  R3 base kept
    {2'd2, 1'b0, 1'b0, 2'd0, 3'd2, 40'h0, 40'h00CD987600},     // 6  R5 index from bus
    {2'd1, 1'b0, 1'b0, 2'd0, 3'd2, 40'hABCD9876EF, 40'h0},     // 5  R5 bus write I2
    {2'd2, 1'b0, 1'b0, 2'd2, 3'd2, 40'h0, 40'h0012345600},     // 4  R6 base zero fill
    {2'd2, 1'b0, 1'b0, 2'd0, 3'd2, 40'h0, 40'h0012345600},     // 3  R3 index armed
    {2'd0, 1'b0, 1'b0, 2'd2, 3'd2, 40'h0000123456, 40'h0},     // 2  R3 base write
    {2'd2, 1'b0, 1'b0, 2'd1, 3'd1, 40'h0, 40'hFF80001000},     // 1  R6 R8 modify sext
    {2'd0, 1'b0, 1'b0, 2'd1, 3'd1, 40'h0000800010, 40'h0}      // 0  R2 write M1
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_lo = 0, sel_hi = 0, wr_en = 0, bw_valid = 0, rq_valid = 0, rsp_ready = 1;
  logic [1:0] wr_kind = 0, bw_kind = 0, rq_kind = 0;
  logic [2:0] wr_idx = 0, bw_idx = 0, rq_idx = 0, ag_sel = 0, ag_msel = 0;
  logic [RW-1:0] wr_data = 0;
  logic [39:0] bw_data = 0;
  logic [RW-1:0] ag_index, ag_base, ag_length, ag_modify;
  logic bw_ready, rq_ready, rsp_valid;
  logic [39:0] rsp_data;
  int checks = 0, errors = 0;
  logic [39:0] held;

  always #4 clk = ~clk;

  addr_bank_regfile #(.REG_W(RW)) i_addr_bank_regfile (
    .clk(clk), .rst_n(rst_n), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data),
    .ag_sel(ag_sel), .ag_index(ag_index), .ag_base(ag_base), .ag_length(ag_length),
    .ag_msel(ag_msel), .ag_modify(ag_modify),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_kind(bw_kind), .bw_idx(bw_idx),
    .bw_data(bw_data), .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_kind(rq_kind),
    .rq_idx(rq_idx), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic gen_write(input logic [1:0] k, input logic [2:0] i, input logic [RW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_kind = k; wr_idx = i; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_write(input logic [1:0] k, input logic [2:0] i, input logic [39:0] d);
    @(negedge clk);
    bw_valid = 1; bw_kind = k; bw_idx = i; bw_data = d;
    @(negedge clk);
    bw_valid = 0;
  endtask

  // Request accepted at the next edge; response checked in the cycle after.
  task automatic bus_read(input string req, input logic [1:0] k, input logic [2:0] i,
                          input logic [39:0] exp);
    @(negedge clk);
    rq_valid = 1; rq_kind = k; rq_idx = i;
    @(negedge clk);
    rq_valid = 0;
    check(req, {39'd0, rsp_valid}, 40'd1);
    check(req, rsp_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: cleared state after reset
    @(negedge clk);
    check("R1 rsp_valid", {39'd0, rsp_valid}, 40'd0);
    check("R1 index", {16'd0, ag_index}, 40'd0);
    check("R1 modify", {16'd0, ag_modify}, 40'd0);

    for (int n = 0; n < NV; n++) begin
      logic [VW-1:0] v;
      v = VEC[n];
      @(negedge clk);
      sel_lo = v[86]; sel_hi = v[85];
      case (v[88:87])
        2'd0: gen_write(v[84:83], v[82:80], v[40 +: RW]);
        2'd1: bus_write(v[84:83], v[82:80], v[79:40]);
        default: bus_read($sformatf("vec%0d", n), v[84:83], v[82:80], v[39:0]);
      endcase
    end

    // R2: taps show visible copies
    @(negedge clk);
    sel_lo = 0; sel_hi = 0; ag_sel = 3'd2; ag_msel = 3'd1;
    #1;
    check("R2 ag_index", {16'd0, ag_index}, 40'h00CD9876);
    check("R2 ag_base", {16'd0, ag_base}, 40'h00123456);
    check("R2 ag_modify", {16'd0, ag_modify}, 40'h00800010);
    sel_lo = 1; ag_sel = 3'd0;
    #1;
    check("R2 ag_length alt", {16'd0, ag_length}, 40'h00000100);

    // R7: bus write stalls under a generator write
    @(negedge clk);
    sel_lo = 0;
    wr_en = 1; wr_kind = 2'd3; wr_idx = 3'd3; wr_data = 24'h000055;
    bw_valid = 1; bw_kind = 2'd3; bw_idx = 3'd6; bw_data = 40'h0000777700;
    #1;
    check("R7 bw_ready low", {39'd0, bw_ready}, 40'd0);
    @(negedge clk);
    wr_en = 0; ag_sel = 3'd6;
    #1;
    check("R7 stalled write no effect", {16'd0, ag_length}, 40'd0);
    check("R7 bw_ready back", {39'd0, bw_ready}, 40'd1);
    @(negedge clk);
    bw_valid = 0;
    #1;
    check("R5 stalled write lands", {16'd0, ag_length}, 40'h00007777);

    // R7: response hold under back-pressure
    @(negedge clk);
    rsp_ready = 0; rq_valid = 1; rq_kind = 2'd3; rq_idx = 3'd3;
    @(negedge clk);
    rq_valid = 0;
    held = rsp_data;
    check("R7 held data", held, 40'h0000005500);
    check("R7 rq_ready low", {39'd0, rq_ready}, 40'd0);
    repeat (2) @(negedge clk);
    check("R7 still valid", {39'd0, rsp_valid}, 40'd1);
    check("R7 stable", rsp_data, held);
    rsp_ready = 1;
    @(negedge clk);
    check("R7 drained", {39'd0, rsp_valid}, 40'd0);

    // R9: read and write on the same edge return the old value
    @(negedge clk);
    rq_valid = 1; rq_kind = 2'd1; rq_idx = 3'd1;
    wr_en = 1; wr_kind = 2'd1; wr_idx = 3'd1; wr_data = 24'h000042;
    @(negedge clk);
    rq_valid = 0; wr_en = 0; ag_msel = 3'd1;
    #1;
    check("R9 old value", rsp_data, 40'hFF80001000);
    check("R9 new value kept", {16'd0, ag_modify}, 40'h00000042);

    // R1: reset mid-run clears both copies
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    sel_hi = 1; ag_msel = 3'd5;
    #1;
    check("R1 alt cleared", {16'd0, ag_modify}, 40'd0);
    sel_lo = 1; ag_sel = 3'd0;
    #1;
    check("R1 alt length cleared", {16'd0, ag_length}, 40'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule